// File: doc/BRIEF.md
# Platform-level interrupt router

This block gathers the external interrupt lines of a system and steers them to a set of hart contexts. A context is one privilege level of one hardware thread, so a thread usually owns two of them (machine and supervisor). Every source carries a programmable priority. Every context carries its own mask of enabled sources and a priority threshold, and drives one request line towards its thread. A source passes through a gateway, an edge or level state machine chosen per source by parameter, before it is seen as pending.

Software services a request in two steps. A claim read on a context's claim/complete word returns the ID of the best eligible source and moves that source into service. A complete write of the same ID then releases it. While a source is in service its gateway raises no new pending bit. An edge gateway remembers one rising edge seen during service and replays it on release. Context slots can be left unpopulated through a parameter mask; an unpopulated slot stays silent.

The default build has ten sources with IDs 1 to 10. Sources 1 to 5 are level sources and 6 to 10 are edge sources. There are ten context slots, and slot 1 is unpopulated because the first thread has only a machine context. Priorities are 3 bits wide.

Top module: `ext_irq_hub`

## Requirements
- R1: After reset every request line is low, the pending word reads 0 and a claim read returns 0.
- R2: A pending source drives only the lines of contexts whose enable mask has that source's bit set (bit position = source ID). A context without the bit gets 0 from a claim.
- R3: A context's line is high only when its best eligible source has a priority strictly greater than its threshold. A source of priority 0 is never delivered. A claim returns 0 whenever the line is low.
- R4: The claim result is the eligible source with the highest priority. On a tie the lowest ID wins.
- R5: A claim read with a nonzero result clears that source's pending bit, and the request line drops if nothing else qualifies.
- R6: A source in service shows no pending bit until a complete write carrying its own ID reaches a populated context. A complete with any other ID leaves it in service.
- R7: A level source becomes pending again right after completion if its input is still high, and goes idle otherwise.
- R8: An edge source remembers at most one rising edge seen during service, and that edge becomes a pending request when the source is completed. An input held high without a new edge raises nothing after completion.
- R9: An unpopulated context never raises its line. Its claim returns 0 and clears no pending bit.
- R10: Register map: addr[11:10]=0 is the priority of source addr[5:0]; =1 is the read-only pending word (bit n = source n); =2 is the enable mask of context addr[7:0]; =3 with addr[0]=0 is the threshold of context addr[9:1], and with addr[0]=1 is that context's claim (read) / complete (write). Read data appears on the cycle after the read strobe.

Two examples of R2: a source-2 priority of 4 with a context threshold of 0 raises that context's line; a threshold equal to the winning priority keeps the line low (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC (bits NSRC:1) | Interrupt inputs; bit n is source ID n |
| irq_o | output | NCTX | One request line per context |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (claim side effect) |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |

## Verification
The hardest case to reach is an edge that arrives while its source is in service. The edge must stay hidden from the pending word, then reappear exactly once after completion. The bench gets there by claiming an edge source, pulsing its input twice during service, and reading the pending word before and after a completion. It then claims again and completes to show that the second pulse was collapsed. Ties and threshold equality come from a vector table that holds two level sources high and rewrites their priorities and the threshold, claiming and completing after each row.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic [1:0] {
        GW_IDLE    = 2'd0,
        GW_PEND    = 2'd1,
        GW_SERVICE = 2'd2,
        GW_HELD    = 2'd3
    } gw_state_e;

    localparam logic [1:0] RGN_PRIO = 2'd0;
    localparam logic [1:0] RGN_PEND = 2'd1;
    localparam logic [1:0] RGN_EN   = 2'd2;
    localparam logic [1:0] RGN_CTX  = 2'd3;

endpackage

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway
    import irq_hub_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o,
    output logic in_service_o
);

    gw_state_e state_q, state_d;
    logic      prev_q;
    logic      rise;
    logic      req;

    assign rise = src_i & ~prev_q;
    assign req  = EDGE ? rise : src_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= src_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE:    if (req) state_d = GW_PEND;
            GW_PEND:    if (claim_i) state_d = GW_SERVICE;
            GW_SERVICE: begin
                if (complete_i)         state_d = req ? GW_PEND : GW_IDLE;
                else if (EDGE && rise)  state_d = GW_HELD;
            end
            GW_HELD:    if (complete_i) state_d = GW_PEND;
            default:    state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending_o    = (state_q == GW_PEND);
        in_service_o = (state_q == GW_SERVICE) || (state_q == GW_HELD);
    end

endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
    parameter int NSRC   = 10,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 4
) (
    input  logic [NSRC:0]              pend_i,
    input  logic [NSRC:0]              en_i,
    input  logic [(NSRC+1)*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]          thr_i,
    input  logic                       present_i,
    output logic [ID_W-1:0]            win_o,
    output logic                       irq_o
);

    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int i = 0; i <= NSRC; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
                best_p  = prio_i[i*PRIO_W +: PRIO_W];
                best_id = ID_W'(i);
            end
        end
    end

    always_comb begin
        if (present_i && (best_p > thr_i)) begin
            irq_o = 1'b1;
            win_o = best_id;
        end else begin
            irq_o = 1'b0;
            win_o = '0;
        end
    end

endmodule

// File: rtl/ext_irq_hub.sv
module ext_irq_hub
    import irq_hub_pkg::*;
#(
    parameter int               NSRC        = 10,
    parameter int               NCTX        = 10,
    parameter int               PRIO_W      = 3,
    parameter logic [NSRC:1]    EDGE_SRC    = 10'b11111_00000,
    parameter logic [NCTX-1:0]  CTX_PRESENT = 10'b11111_11101
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC:1]   src_i,
    output logic [NCTX-1:0] irq_o,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [11:0]     reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata
);

    localparam int ID_W  = $clog2(NSRC + 1);
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int PF_W  = (NSRC + 1) * PRIO_W;

    logic [PF_W-1:0]   prio_q;
    logic [NSRC:0]     en_q  [NCTX];
    logic [PRIO_W-1:0] thr_q [NCTX];

    logic [NSRC:0]     pend_vec;
    logic [NSRC:0]     insvc_vec;
    logic [ID_W-1:0]   win_id [NCTX];

    logic [1:0]        region;
    logic [5:0]        src_sel;
    logic              src_ok;
    logic [7:0]        ectx;
    logic              ectx_ok;
    logic [8:0]        cctx;
    logic              cctx_in;
    logic              cctx_ok;
    logic [CTX_W-1:0]  eidx;
    logic [CTX_W-1:0]  claim_ctx;
    logic              claim_go;
    logic [ID_W-1:0]   claim_id;
    logic              complete_go;
    logic [ID_W-1:0]   complete_id;
    logic [31:0]       rd_next;

    assign region    = reg_addr[11:10];
    assign src_sel   = reg_addr[5:0];
    assign src_ok    = (src_sel != 6'd0) && (32'(src_sel) <= NSRC);
    assign ectx      = reg_addr[7:0];
    assign ectx_ok   = 32'(ectx) < NCTX;
    assign eidx      = ectx[CTX_W-1:0];
    assign cctx      = reg_addr[9:1];
    assign cctx_in   = 32'(cctx) < NCTX;
    assign claim_ctx = cctx[CTX_W-1:0];
    assign cctx_ok   = cctx_in && CTX_PRESENT[claim_ctx];

    assign claim_go    = reg_re && (region == RGN_CTX) && reg_addr[0] && cctx_ok;
    assign claim_id    = claim_go ? win_id[claim_ctx] : '0;
    assign complete_go = reg_we && (region == RGN_CTX) && reg_addr[0] && cctx_ok
                         && (reg_wdata != 32'd0) && (reg_wdata <= 32'(NSRC));
    assign complete_id = reg_wdata[ID_W-1:0];

    assign pend_vec[0]  = 1'b0;
    assign insvc_vec[0] = 1'b0;

    for (genvar s = 1; s <= NSRC; s++) begin : g_src
        irq_hub_gateway #(.EDGE(EDGE_SRC[s])) u_gw (
            .clk          (clk),
            .rst_n        (rst_n),
            .src_i        (src_i[s]),
            .claim_i      (claim_go && (claim_id == ID_W'(s))),
            .complete_i   (complete_go && (complete_id == ID_W'(s))),
            .pending_o    (pend_vec[s]),
            .in_service_o (insvc_vec[s])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irq_hub_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .pend_i    (pend_vec),
            .en_i      (en_q[c]),
            .prio_i    (prio_q),
            .thr_i     (thr_q[c]),
            .present_i (CTX_PRESENT[c]),
            .win_o     (win_id[c]),
            .irq_o     (irq_o[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (reg_we) begin
            if (region == RGN_PRIO && src_ok)
                prio_q[32'(src_sel)*PRIO_W +: PRIO_W] <= reg_wdata[PRIO_W-1:0];
            if (region == RGN_EN && ectx_ok)
                en_q[eidx] <= {reg_wdata[NSRC:1], 1'b0};
            if (region == RGN_CTX && !reg_addr[0] && cctx_in)
                thr_q[claim_ctx] <= reg_wdata[PRIO_W-1:0];
        end
    end

    always_comb begin
        rd_next = 32'd0;
        unique case (region)
            RGN_PRIO: if (src_ok) rd_next = 32'(prio_q[32'(src_sel)*PRIO_W +: PRIO_W]);
            RGN_PEND: rd_next = 32'(pend_vec);
            RGN_EN:   if (ectx_ok) rd_next = 32'(en_q[eidx]);
            RGN_CTX: begin
                if (!reg_addr[0] && cctx_in) rd_next = 32'(thr_q[claim_ctx]);
                else if (reg_addr[0])        rd_next = 32'(claim_id);
            end
            default:  rd_next = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= 32'd0;
        else if (reg_re) reg_rdata <= rd_next;
    end

endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
    parameter int              NSRC        = 10,
    parameter int              NCTX        = 10,
    parameter int              ID_W        = 4,
    parameter int              CTX_W       = 4,
    parameter logic [NSRC:1]   EDGE_SRC    = '0,
    parameter logic [NCTX-1:0] CTX_PRESENT = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC:1]   src_i,
    input logic [NCTX-1:0] irq_o,
    input logic [31:0]     reg_rdata,
    input logic [NSRC:0]   pend_vec,
    input logic [NSRC:0]   insvc_vec,
    input logic            claim_go,
    input logic [CTX_W-1:0] claim_ctx,
    input logic [ID_W-1:0] claim_id,
    input logic            complete_go,
    input logic [ID_W-1:0] complete_id
);

    a_r9_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~CTX_PRESENT) == '0);

    a_r3_low_line_claims_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_go && !irq_o[claim_ctx]) |=> (reg_rdata == 32'd0));

    a_r4_high_line_claims_id: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_go && irq_o[claim_ctx]) |=> (reg_rdata != 32'd0));

    a_r5_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_go && claim_id != '0) |=> !pend_vec[$past(claim_id)]);

    for (genvar s = 1; s <= NSRC; s++) begin : g_chk
        a_r6_no_repend_in_service: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_vec[s]) |->
                $past(!insvc_vec[s] || (complete_go && complete_id == ID_W'(s))));

        if (!EDGE_SRC[s]) begin : g_lvl
            a_r7_level_repend: assert property (@(posedge clk) disable iff (!rst_n)
                (complete_go && complete_id == ID_W'(s) && insvc_vec[s] && src_i[s])
                    |=> pend_vec[s]);
        end
    end

endmodule

bind ext_irq_hub irq_hub_checker #(
    .NSRC(NSRC), .NCTX(NCTX), .ID_W(ID_W), .CTX_W(CTX_W),
    .EDGE_SRC(EDGE_SRC), .CTX_PRESENT(CTX_PRESENT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .irq_o(irq_o),
    .reg_rdata(reg_rdata), .pend_vec(pend_vec), .insvc_vec(insvc_vec),
    .claim_go(claim_go), .claim_ctx(claim_ctx), .claim_id(claim_id),
    .complete_go(complete_go), .complete_id(complete_id)
);

// File: tb/tb_ext_irq_hub.sv
`timescale 1ns/1ps
module tb_ext_irq_hub;

    localparam int NSRC = 10;
    localparam int NCTX = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:1]   src = '0;
    logic [NCTX-1:0] irq;
    logic            we = 1'b0;
    logic            re = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ext_irq_hub dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .irq_o(irq),
        .reg_we(we), .reg_re(re), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata)
    );

    // rows: priority of source 3, priority of source 5, threshold, expected claim, expected line
    localparam int VEC [8][5] = '{
        '{3, 5, 0, 5, 1},
        '{6, 2, 0, 3, 1},
        '{4, 4, 0, 3, 1},
        '{4, 4, 4, 0, 0},
        '{4, 2, 3, 3, 1},
        '{0, 1, 0, 5, 1},
        '{0, 0, 0, 0, 0},
        '{7, 7, 6, 3, 1}
    };

    function automatic logic [11:0] a_prio(int id); return 12'(id); endfunction
    function automatic logic [11:0] a_pend();       return 12'h400; endfunction
    function automatic logic [11:0] a_en(int c);    return 12'h800 | 12'(c); endfunction
    function automatic logic [11:0] a_thr(int c);   return 12'hC00 | 12'(c << 1); endfunction
    function automatic logic [11:0] a_clm(int c);   return 12'hC01 | 12'(c << 1); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); re = 1'b1; addr = a;
        @(negedge clk); re = 1'b0; d = rdata;
    endtask

    task automatic tick(); @(negedge clk); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 lines", 32'(irq), 32'd0);
        rd(a_pend(), d);   chk("R1 pending", d, 32'd0);
        rd(a_clm(0), d);   chk("R1 claim", d, 32'd0);

        // R4 / R3 table: sources 3 and 5 (level) held high, context 0
        wr(a_en(0), 32'h28);
        src[3] = 1'b1; src[5] = 1'b1;
        tick(); tick();
        for (int v = 0; v < 8; v++) begin
            wr(a_prio(3), 32'(VEC[v][0]));
            wr(a_prio(5), 32'(VEC[v][1]));
            wr(a_thr(0),  32'(VEC[v][2]));
            chk($sformatf("R3 line row %0d", v), 32'(irq[0]), 32'(VEC[v][4]));
            rd(a_clm(0), d);
            chk($sformatf("R4 claim row %0d", v), d, 32'(VEC[v][3]));
            if (VEC[v][3] != 0) wr(a_clm(0), 32'(VEC[v][3]));
        end
        wr(a_prio(3), 0); wr(a_prio(5), 0);

        // R2 per-context enable, R9 absent context, source 2 level
        wr(a_prio(2), 4);
        wr(a_en(3), 32'h4);
        wr(a_en(4), 32'h0);
        wr(a_en(1), 32'h4);
        src[2] = 1'b1; tick(); tick();
        chk("R2 enabled context line", 32'(irq[3]), 1);
        chk("R2 masked context line", 32'(irq[4]), 0);
        rd(a_clm(4), d);  chk("R2 masked claim", d, 0);
        chk("R9 absent line", 32'(irq[1]), 0);
        rd(a_clm(1), d);  chk("R9 absent claim", d, 0);
        rd(a_pend(), d);  chk("R9 pending kept", d & 32'h4, 32'h4);

        // R5 claim clears, R6 wrong complete ignored, R7 level idle
        rd(a_clm(3), d);  chk("R5 claim id", d, 2);
        chk("R5 line drops", 32'(irq[3]), 0);
        rd(a_pend(), d);  chk("R5 pending cleared", d & 32'h4, 0);
        wr(a_clm(3), 4);
        tick();
        rd(a_pend(), d);  chk("R6 wrong complete", d & 32'h4, 0);
        src[2] = 1'b0; tick();
        wr(a_clm(3), 2);
        tick();
        rd(a_pend(), d);  chk("R7 level idle", d & 32'h4, 0);
        src[2] = 1'b1; tick(); tick();
        rd(a_clm(3), d);  chk("R7 reclaim", d, 2);
        wr(a_clm(3), 2);
        rd(a_pend(), d);  chk("R7 level repend", d & 32'h4, 32'h4);
        src[2] = 1'b0;

        // R8 edge source 7
        wr(a_prio(7), 2);
        wr(a_en(2), 32'h80);
        src[7] = 1'b1; tick(); src[7] = 1'b0; tick();
        chk("R8 edge line", 32'(irq[2]), 1);
        rd(a_clm(2), d);  chk("R8 edge claim", d, 7);
        src[7] = 1'b1; tick(); src[7] = 1'b0; tick();
        src[7] = 1'b1; tick(); src[7] = 1'b0; tick();
        rd(a_pend(), d);  chk("R6 edge hidden in service", d & 32'h80, 0);
        chk("R6 edge line low", 32'(irq[2]), 0);
        wr(a_clm(2), 7);
        rd(a_pend(), d);  chk("R8 edge replayed", d & 32'h80, 32'h80);
        rd(a_clm(2), d);  chk("R8 second claim", d, 7);
        wr(a_clm(2), 7);
        tick();
        rd(a_pend(), d);  chk("R8 edges collapsed", d & 32'h80, 0);
        src[7] = 1'b1; tick(); tick();
        rd(a_clm(2), d);  chk("R8 held claim", d, 7);
        wr(a_clm(2), 7);
        tick();
        rd(a_pend(), d);  chk("R8 held no repend", d & 32'h80, 0);

        // R10 register readback
        rd(a_prio(7), d); chk("R10 priority read", d, 2);
        rd(a_en(2), d);   chk("R10 enable read", d, 32'h80);
        wr(a_thr(2), 5);
        rd(a_thr(2), d);  chk("R10 threshold read", d, 5);
        rd(a_prio(0), d); chk("R10 id0 priority", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule